// File: doc/BRIEF.md
# Digital DAC Setpoint Ramp Controller

This block moves a DAC setpoint from its current value toward a programmed target in periodic steps. The setpoint is held in a fixed-point accumulator whose fractional bits sit below the DAC LSB, so a step may be smaller than one DAC code. A ramp is armed by one of several external start events, picked by a select field. It waits out a programmable pre-ramp delay, then updates once every programmable period until it reaches the target.

While a ramp runs, two saturation flags from the error converter can take over the update. A high flag pulls the setpoint down by a separate saturation step, and a low flag pushes it up. This can make the ramp non-monotonic. Sticky status flags record completion, saturation corrections and accepted starts. Each flag has its own interrupt enable, and the interrupt line is the OR of the enabled flags. Software configures the block through a simple write port.

Top module: `ramp_setpoint_ctrl`

## Requirements
- R1: After reset, dac_out is 0, busy is 0, status is 0 and irq is 0.
- R2: A start event is accepted only while the enable bit (control register, address 0, bit 0) is 1. Clearing that bit during a delay or a ramp returns the block to idle on the following cycle, and dac_out keeps its value.
- R3: The start source is the start_evt bit whose index is held in control bits [2:1]. A pulse on any other start_evt bit has no effect.
- R4: With delay D (address 5), period P (address 6) and N updates, busy is high for exactly (D+1)+N*(P+1) cycles, counted from the clock edge that accepts the start.
- R5: The accumulator keeps 6 fractional bits below dac_out (dac_out = accumulator >> 6). On each update it moves by the step value (address 3, in 1/64 LSB) toward the end value (address 2). Between updates it holds.
- R6: The ramp finishes on the first update that would reach or pass the end value. dac_out then equals the end value exactly, status bit 0 is set, and the block returns to idle. When start and end are equal, one update is needed.
- R7: On an update with sat_hi set, the accumulator drops by the saturation step (address 4), with a floor at 0, and status bit 1 is set. sat_hi takes priority over sat_lo.
- R8: On an update with only sat_lo set, the accumulator rises by the saturation step, with a ceiling at full scale, and status bit 2 is set. The ramp resumes normal stepping once saturation clears.
- R9: Status bits are sticky and are cleared by writing a 1 to them at address 7. Bit 3 is set when a start is accepted.
- R10: irq is 1 exactly when some status bit and its enable bit (address 8, same position) are both 1.
- R11: A start event that arrives during a delay or a ramp is ignored, and status bit 3 stays clear.
- R12: A write to the setpoint register (address 1) loads dac_out only while idle. While busy, the write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_evt | input | NSRC | Start event inputs, one bit per source |
| sat_hi | input | 1 | Error converter saturated high |
| sat_lo | input | 1 | Error converter saturated low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | DAC_W+FRAC_W | Register write data |
| dac_out | output | DAC_W | DAC setpoint code |
| busy | output | 1 | Delay or ramp in progress |
| status | output | 4 | Sticky event flags |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle, the assertions check several properties. A disable always drops the sequencer to idle. The idle state never jumps straight into ramping. The accumulator holds between updates. A completing update lands exactly on the target, a high-saturation update never raises the setpoint, and status flags persist until cleared. The bench scenarios cover the rest: cycle-exact ramp durations across many delay, period and step combinations, sub-LSB stepping, and the non-monotonic path under saturation and its recovery. They also cover the cases where something must have no effect: a start on a different source, a start while busy, a setpoint write while busy, and a start while disabled.

// File: rtl/rampctl_pkg.sv
package rampctl_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DELAY, ST_RAMP} ramp_st_e;

  localparam int NFLAG    = 4;
  localparam int FLG_DONE = 0;
  localparam int FLG_SHI  = 1;
  localparam int FLG_SLO  = 2;
  localparam int FLG_STRT = 3;

  localparam logic [3:0] A_CTRL  = 4'd0;
  localparam logic [3:0] A_SETPT = 4'd1;
  localparam logic [3:0] A_END   = 4'd2;
  localparam logic [3:0] A_STEP  = 4'd3;
  localparam logic [3:0] A_SSTEP = 4'd4;
  localparam logic [3:0] A_DLY   = 4'd5;
  localparam logic [3:0] A_PER   = 4'd6;
  localparam logic [3:0] A_STAT  = 4'd7;
  localparam logic [3:0] A_IEN   = 4'd8;
endpackage

// File: rtl/ramp_regs.sv
module ramp_regs
  import rampctl_pkg::*;
#(
  parameter int DAC_W = 10,
  parameter int ACC_W = 16,
  parameter int DLY_W = 8,
  parameter int PER_W = 8,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       wr_addr,
  input  logic [ACC_W-1:0] wr_data,
  input  logic             busy,
  input  logic [NFLAG-1:0] flag_set,
  output logic             ctl_en,
  output logic [SEL_W-1:0] ctl_sel,
  output logic [DAC_W-1:0] end_val,
  output logic [ACC_W-1:0] step,
  output logic [ACC_W-1:0] satstep,
  output logic [DLY_W-1:0] delay,
  output logic [PER_W-1:0] period,
  output logic             sp_load,
  output logic [DAC_W-1:0] sp_val,
  output logic [NFLAG-1:0] status,
  output logic             irq
);
  logic             ctl_en_n;
  logic [SEL_W-1:0] ctl_sel_n;
  logic [DAC_W-1:0] end_n;
  logic [ACC_W-1:0] step_n, satstep_n;
  logic [DLY_W-1:0] delay_n;
  logic [PER_W-1:0] period_n;
  logic [NFLAG-1:0] status_n, ien, ien_n, w1c, hit;

  always_comb begin
    ctl_en_n  = ctl_en;
    ctl_sel_n = ctl_sel;
    end_n     = end_val;
    step_n    = step;
    satstep_n = satstep;
    delay_n   = delay;
    period_n  = period;
    ien_n     = ien;
    w1c       = '0;
    if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin
          ctl_en_n  = wr_data[0];
          ctl_sel_n = wr_data[SEL_W:1];
        end
        A_END:   end_n     = wr_data[DAC_W-1:0];
        A_STEP:  step_n    = wr_data;
        A_SSTEP: satstep_n = wr_data;
        A_DLY:   delay_n   = wr_data[DLY_W-1:0];
        A_PER:   period_n  = wr_data[PER_W-1:0];
        A_STAT:  w1c       = wr_data[NFLAG-1:0];
        A_IEN:   ien_n     = wr_data[NFLAG-1:0];
        default: ;
      endcase
    end
    status_n = (status & ~w1c) | flag_set;
  end

  assign sp_load = wr_en && (wr_addr == A_SETPT) && !busy;
  assign sp_val  = wr_data[DAC_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en  <= 1'b0;
      ctl_sel <= '0;
      end_val <= '0;
      step    <= '0;
      satstep <= '0;
      delay   <= '0;
      period  <= '0;
      ien     <= '0;
      status  <= '0;
    end else begin
      ctl_en  <= ctl_en_n;
      ctl_sel <= ctl_sel_n;
      end_val <= end_n;
      step    <= step_n;
      satstep <= satstep_n;
      delay   <= delay_n;
      period  <= period_n;
      ien     <= ien_n;
      status  <= status_n;
    end
  end

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    assign hit[i] = status[i] & ien[i];

    // R9: a set flag survives unless a one is written to it
    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (status[i] && !(wr_en && wr_addr == A_STAT && wr_data[i])) |=> status[i]);
  end

  assign irq = |hit;
endmodule

// File: rtl/ramp_seq.sv
module ramp_seq
  import rampctl_pkg::*;
#(
  parameter int NSRC  = 4,
  parameter int SEL_W = 2,
  parameter int DLY_W = 8,
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  input  logic [NSRC-1:0]  start_evt,
  input  logic [DLY_W-1:0] delay,
  input  logic [PER_W-1:0] period,
  input  logic             done,
  output logic             busy,
  output logic             tick,
  output logic             start_acc
);
  ramp_st_e         st, st_n;
  logic [DLY_W-1:0] dcnt, dcnt_n;
  logic [PER_W-1:0] pcnt, pcnt_n;
  logic             trig;

  assign trig = (int'(sel) < NSRC) ? start_evt[sel] : 1'b0;

  always_comb begin
    st_n      = st;
    dcnt_n    = dcnt;
    pcnt_n    = pcnt;
    tick      = 1'b0;
    start_acc = 1'b0;
    case (st)
      ST_IDLE: begin
        if (en && trig) begin
          st_n      = ST_DELAY;
          dcnt_n    = delay;
          start_acc = 1'b1;
        end
      end
      ST_DELAY: begin
        if (!en) st_n = ST_IDLE;
        else if (dcnt == '0) begin
          st_n   = ST_RAMP;
          pcnt_n = period;
        end else dcnt_n = dcnt - 1'b1;
      end
      ST_RAMP: begin
        if (!en) st_n = ST_IDLE;
        else if (pcnt == '0) begin
          tick   = 1'b1;
          pcnt_n = period;
          if (done) st_n = ST_IDLE;
        end else pcnt_n = pcnt - 1'b1;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      dcnt <= '0;
      pcnt <= '0;
    end else begin
      st   <= st_n;
      dcnt <= dcnt_n;
      pcnt <= pcnt_n;
    end
  end

  assign busy = (st != ST_IDLE);

  // R2: disable always forces idle on the next cycle
  assert_abort_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !en) |=> !busy);
  // R4: a ramp is always preceded by the delay phase
  assert_delay_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |=> (st != ST_RAMP));
endmodule

// File: rtl/ramp_accum.sv
module ramp_accum #(
  parameter int DAC_W  = 10,
  parameter int FRAC_W = 6,
  parameter int ACC_W  = DAC_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             sat_hi,
  input  logic             sat_lo,
  input  logic [ACC_W-1:0] step,
  input  logic [ACC_W-1:0] satstep,
  input  logic [DAC_W-1:0] end_val,
  input  logic             sp_load,
  input  logic [DAC_W-1:0] sp_val,
  output logic [DAC_W-1:0] dac_out,
  output logic             done,
  output logic             shi_ev,
  output logic             slo_ev
);
  logic [ACC_W-1:0] acc, acc_n, end_acc, dist_dn;
  logic [ACC_W:0]   sum_up, sum_sat;
  logic             up;

  assign end_acc = {end_val, {FRAC_W{1'b0}}};
  assign up      = end_acc > acc;
  assign sum_up  = {1'b0, acc} + {1'b0, step};
  assign sum_sat = {1'b0, acc} + {1'b0, satstep};
  assign dist_dn = acc - end_acc;

  always_comb begin
    acc_n  = acc;
    done   = 1'b0;
    shi_ev = 1'b0;
    slo_ev = 1'b0;
    if (tick) begin
      if (sat_hi) begin
        shi_ev = 1'b1;
        acc_n  = (acc > satstep) ? (acc - satstep) : '0;
      end else if (sat_lo) begin
        slo_ev = 1'b1;
        acc_n  = sum_sat[ACC_W] ? '1 : sum_sat[ACC_W-1:0];
      end else if (up) begin
        if (sum_up >= {1'b0, end_acc}) begin
          acc_n = end_acc;
          done  = 1'b1;
        end else acc_n = sum_up[ACC_W-1:0];
      end else begin
        if (step >= dist_dn) begin
          acc_n = end_acc;
          done  = 1'b1;
        end else acc_n = acc - step;
      end
    end else if (sp_load) begin
      acc_n = {sp_val, {FRAC_W{1'b0}}};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc <= '0;
    else        acc <= acc_n;
  end

  assign dac_out = acc[ACC_W-1:FRAC_W];

  // R5: accumulator holds between updates
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !sp_load) |=> $stable(acc));
  // R6: completion lands exactly on the target
  assert_clamp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (dac_out == $past(end_val)));
  // R7: a high-saturation update never raises the setpoint
  assert_sat_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && sat_hi) |=> (acc <= $past(acc)));
endmodule

// File: rtl/ramp_setpoint_ctrl.sv
module ramp_setpoint_ctrl
  import rampctl_pkg::*;
#(
  parameter int DAC_W  = 10,
  parameter int FRAC_W = 6,
  parameter int DLY_W  = 8,
  parameter int PER_W  = 8,
  parameter int NSRC   = 4,
  localparam int ACC_W = DAC_W + FRAC_W,
  localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  start_evt,
  input  logic             sat_hi,
  input  logic             sat_lo,
  input  logic             wr_en,
  input  logic [3:0]       wr_addr,
  input  logic [ACC_W-1:0] wr_data,
  output logic [DAC_W-1:0] dac_out,
  output logic             busy,
  output logic [NFLAG-1:0] status,
  output logic             irq
);
  logic             ctl_en, sp_load, tick, done, shi_ev, slo_ev, start_acc;
  logic [SEL_W-1:0] ctl_sel;
  logic [DAC_W-1:0] end_val, sp_val;
  logic [ACC_W-1:0] step, satstep;
  logic [DLY_W-1:0] delay;
  logic [PER_W-1:0] period;
  logic [NFLAG-1:0] flag_set;

  always_comb begin
    flag_set           = '0;
    flag_set[FLG_DONE] = done;
    flag_set[FLG_SHI]  = shi_ev;
    flag_set[FLG_SLO]  = slo_ev;
    flag_set[FLG_STRT] = start_acc;
  end

  ramp_regs #(.DAC_W(DAC_W), .ACC_W(ACC_W), .DLY_W(DLY_W), .PER_W(PER_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .flag_set(flag_set), .ctl_en(ctl_en), .ctl_sel(ctl_sel),
    .end_val(end_val), .step(step), .satstep(satstep), .delay(delay), .period(period),
    .sp_load(sp_load), .sp_val(sp_val), .status(status), .irq(irq));

  ramp_seq #(.NSRC(NSRC), .SEL_W(SEL_W), .DLY_W(DLY_W), .PER_W(PER_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(ctl_en), .sel(ctl_sel), .start_evt(start_evt),
    .delay(delay), .period(period), .done(done), .busy(busy), .tick(tick),
    .start_acc(start_acc));

  ramp_accum #(.DAC_W(DAC_W), .FRAC_W(FRAC_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sat_hi(sat_hi), .sat_lo(sat_lo),
    .step(step), .satstep(satstep), .end_val(end_val), .sp_load(sp_load), .sp_val(sp_val),
    .dac_out(dac_out), .done(done), .shi_ev(shi_ev), .slo_ev(slo_ev));
endmodule

// File: tb/tb_ramp_setpoint_ctrl.sv
module tb_ramp_setpoint_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  start_evt = '0;
  logic        sat_hi = 1'b0, sat_lo = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [9:0]  dac_out;
  logic        busy, irq;
  logic [3:0]  status;
  int          n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  ramp_setpoint_ctrl dut (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .sat_hi(sat_hi), .sat_lo(sat_lo),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dac_out(dac_out), .busy(busy), .status(status), .irq(irq));

  // vector fields: start[51:42] end[41:32] step[31:16] period[15:8] delay[7:0]
  localparam int NV = 6;
  localparam logic [51:0] VEC [NV] = '{
    {10'd100,  10'd200,  16'd64,    8'd0, 8'd0},
    {10'd500,  10'd100,  16'd640,   8'd1, 8'd2},
    {10'd0,    10'd1023, 16'd100,   8'd0, 8'd0},
    {10'd300,  10'd300,  16'd64,    8'd2, 8'd1},
    {10'd10,   10'd11,   16'd5,     8'd0, 8'd0},
    {10'd1023, 10'd0,    16'd65535, 8'd3, 8'd0}
  };

  task automatic chk(input string req, input int act, input int exp_v);
    n_run++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    start_evt[idx] = 1'b1;
    @(negedge clk);
    start_evt = '0;
  endtask

  task automatic busy_len(output int cnt);
    cnt = 0;
    while (busy && cnt < 20000) begin
      cnt++;
      @(negedge clk);
    end
  endtask

  task automatic setup(input int sp, input int ev, input int st, input int per, input int dly);
    wr(4'd0, 16'd0);
    wr(4'd1, 16'(sp));
    wr(4'd2, 16'(ev));
    wr(4'd3, 16'(st));
    wr(4'd6, 16'(per));
    wr(4'd5, 16'(dly));
    wr(4'd7, 16'hF);
    wr(4'd0, 16'd1);
  endtask

  initial begin
    int cnt, nup, diff, hold;
    #3;
    chk("R1 dac", int'(dac_out), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 status", int'(status), 0);
    chk("R1 irq", int'(irq), 0);
    @(negedge clk); rst_n = 1'b1;

    // vector table: duration, exact landing, done flag
    for (int v = 0; v < NV; v++) begin
      int sp, ev, st, per, dly;
      sp = int'(VEC[v][51:42]); ev = int'(VEC[v][41:32]); st = int'(VEC[v][31:16]);
      per = int'(VEC[v][15:8]); dly = int'(VEC[v][7:0]);
      setup(sp, ev, st, per, dly);
      chk("R12 load idle", int'(dac_out), sp);
      diff = (ev > sp ? ev - sp : sp - ev) * 64;
      nup = (diff == 0) ? 1 : (diff + st - 1) / st;
      pulse(0);
      busy_len(cnt);
      chk("R4 R5 duration", cnt, (dly + 1) + nup * (per + 1));
      chk("R6 end value", int'(dac_out), ev);
      chk("R6 done flag", int'(status[0]), 1);
      chk("R9 start flag", int'(status[3]), 1);
    end

    // R10: interrupt mask
    chk("R10 masked", int'(irq), 0);
    wr(4'd8, 16'h1);
    chk("R10 enabled", int'(irq), 1);
    wr(4'd7, 16'h1);
    chk("R9 w1c done", int'(status[0]), 0);
    chk("R10 cleared", int'(irq), 0);
    wr(4'd8, 16'h0);

    // R2: disabled start ignored
    setup(50, 60, 64, 0, 0);
    wr(4'd0, 16'd0);
    pulse(0);
    chk("R2 disabled busy", int'(busy), 0);
    chk("R2 disabled flag", int'(status[3]), 0);

    // R3: source select = 2
    wr(4'd0, 16'h5);
    pulse(1);
    chk("R3 other src busy", int'(busy), 0);
    chk("R3 other src flag", int'(status[3]), 0);
    pulse(2);
    chk("R3 selected src", int'(busy), 1);
    busy_len(cnt);
    chk("R3 end", int'(dac_out), 60);

    // R11: start during ramp ignored
    setup(0, 50, 64, 3, 0);
    pulse(0);
    wr(4'd7, 16'h8);
    pulse(0);
    chk("R11 flag stays clear", int'(status[3]), 0);
    busy_len(cnt);
    chk("R11 ramp unaffected", int'(dac_out), 50);

    // R12: setpoint write ignored while busy
    setup(40, 80, 64, 0, 200);
    pulse(0);
    wr(4'd1, 16'd777);
    chk("R12 busy write", int'(dac_out), 40);

    // R2: abort mid ramp
    wr(4'd0, 16'd0);
    @(negedge clk);
    chk("R2 abort", int'(busy), 0);
    setup(0, 900, 64, 0, 0);
    pulse(0);
    repeat (10) @(negedge clk);
    wr(4'd0, 16'd0);
    @(negedge clk);
    chk("R2 abort ramp", int'(busy), 0);
    hold = int'(dac_out);
    repeat (5) @(negedge clk);
    chk("R2 dac holds", int'(dac_out), hold);

    // R7: saturated high during an upward ramp
    setup(500, 900, 64, 0, 0);
    wr(4'd4, 16'd320);
    sat_hi = 1'b1; sat_lo = 1'b1;
    pulse(0);
    repeat (4) @(negedge clk);
    chk("R7 lowered", int'(dac_out), 485);
    chk("R7 flag", int'(status[1]), 1);
    chk("R7 priority", int'(status[2]), 0);
    sat_hi = 1'b0; sat_lo = 1'b0;
    busy_len(cnt);
    chk("R7 recovers", int'(dac_out), 900);

    // R8: saturated low during a downward ramp
    setup(500, 100, 64, 0, 0);
    sat_lo = 1'b1;
    pulse(0);
    repeat (4) @(negedge clk);
    chk("R8 raised", int'(dac_out), 515);
    chk("R8 flag", int'(status[2]), 1);
    sat_lo = 1'b0;
    busy_len(cnt);
    chk("R8 recovers", int'(dac_out), 100);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule